// File: doc/BRIEF.md
# Dual-Bank Programmable-Trigger Interrupt Controller

This block collects 32 external interrupt lines and presents them to a processor through two register banks of the same shape: a normal bank and a fast bank, each with its own interrupt output. Each line's input passes through a two-flop synchronizer. In each bank, software picks for every line whether it is level or edge sensitive and which polarity counts as active. It also picks which lines are allowed to raise the bank's output.

Edge-sensitive lines hold a detected edge in a sticky latch until software writes a one to that line's bit in the clear register. Level-sensitive lines follow the corrected input directly. The status register holds the enabled pending lines. A handler services the lowest set bit and reads status again until it is zero. Register access uses a plain synchronous bus. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `intc_top`

## Requirements
- R1: After reset, every mask, mode and polarity bit and every edge latch is 0, status reads 0 in both banks, and both interrupt outputs are low.
- R2: Word offsets within a bank are: source 0x00, mask 0x04, clear 0x08, mode 0x0C, polarity 0x10, status 0x14. The normal bank sits at base 0x00 and the fast bank at base 0x20 (address bit 5 selects the bank). Mask, mode and polarity read back what was written.
- R3: Status equals the pending lines ANDed with mask, where mask bit 1 enables a line. A bank's interrupt output is high exactly when its status is nonzero.
- R4: The source register reads each line after polarity correction (input XOR polarity bit), with no masking applied.
- R5: With mode bit 0 (level), a line is pending while its input is 1 when its polarity bit is 0, or while its input is 0 when its polarity bit is 1.
- R6: With mode bit 1 (edge), a 0-to-1 transition (polarity 0) or a 1-to-0 transition (polarity 1) sets the line's latch. The latch stays set after the input returns, until it is cleared.
- R7: Writing the clear register clears the latches at the bit positions written as 1. Bits written as 0 have no effect, and clearing a level-mode line leaves its pending state unchanged.
- R8: When an edge on a line and a clear of that line fall in the same cycle, the latch stays set.
- R9: Unmapped addresses, including any with address bits [1:0] nonzero, offsets 0x18 to 0x1C and 0x38 to 0x3C, and anything at or above 0x40, read as 0. The clear register reads as 0.
- R10: A change at an input line appears in the source register after two rising clock edges, not after one.
- R11: The two banks are independent. A write to one bank's mask, mode or polarity does not change the other bank's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Raw interrupt inputs, one per line |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_norm | output | 1 | Normal-bank interrupt request |
| irq_fast | output | 1 | Fast-bank interrupt request |

## Verification
On every cycle, the assertions check four things: a detected edge on an edge-mode line always sets its latch on the next edge; a latch not hit by a clear is never lost; a bank with an all-zero mask keeps its output low; and unmapped reads return zero. Several behaviours only show up in the bench scenarios, because they span register writes and input sequences: the two-edge input latency, the polarity choices in both trigger modes, the partial clears, the clears that leave level-mode lines unaffected, the collision of a clear with a new edge, bank independence, and randomized configurations checked against a model derived from the requirements.

// File: rtl/intc_pkg.sv
package intc_pkg;
    // Register index inside a bank, taken from byte address bits [4:2].
    typedef enum logic [2:0] {
        REG_SRC  = 3'd0,
        REG_MASK = 3'd1,
        REG_CLR  = 3'd2,
        REG_MODE = 3'd3,
        REG_POL  = 3'd4,
        REG_STAT = 3'd5
    } reg_idx_t;

    localparam int unsigned BANK_SEL_BIT = 5;
    localparam int unsigned NUM_BANKS    = 2;
    localparam logic [2:0]  LAST_REG     = 3'd5;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic         wr_en_i,
    input  reg_idx_t     idx_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] rd_data_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] mode;
        logic [N-1:0] pol;
        logic [N-1:0] latch;
        logic [N-1:0] prev;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [N-1:0] corr_d;
    logic [N-1:0] det_d;
    logic [N-1:0] clr_d;
    logic [N-1:0] pend_d;
    logic [N-1:0] status_d;

    always_comb begin
        corr_d   = lines_i ^ st_q.pol;
        det_d    = (lines_i & ~st_q.prev & ~st_q.pol) |
                   (~lines_i & st_q.prev & st_q.pol);
        clr_d    = (wr_en_i && idx_i == REG_CLR) ? wr_data_i : '0;
        pend_d   = (st_q.mode & st_q.latch) | (~st_q.mode & corr_d);
        status_d = pend_d & st_q.mask;

        st_d       = st_q;
        st_d.prev  = lines_i;
        // A fresh edge wins over a clear of the same bit.
        st_d.latch = (st_q.latch & ~clr_d) | (det_d & st_q.mode);
        if (wr_en_i) begin
            case (idx_i)
                REG_MASK: st_d.mask = wr_data_i;
                REG_MODE: st_d.mode = wr_data_i;
                REG_POL:  st_d.pol  = wr_data_i;
                default:  ;
            endcase
        end

        case (idx_i)
            REG_SRC:  rd_data_o = corr_d;
            REG_MASK: rd_data_o = st_q.mask;
            REG_MODE: rd_data_o = st_q.mode;
            REG_POL:  rd_data_o = st_q.pol;
            REG_STAT: rd_data_o = status_d;
            default:  rd_data_o = '0;
        endcase
        irq_o = |status_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_EDGE_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & $past(det_d & st_q.mode)) == $past(det_d & st_q.mode))); // R8
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & $past(st_q.latch & ~clr_d)) == $past(st_q.latch & ~clr_d))); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq_o); // R3
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SYNC_STG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_norm,
    output logic                 irq_fast
);
    localparam int unsigned HI_LSB = BANK_SEL_BIT + 1;

    logic [NUM_LINES-1:0] lines_s;
    logic                 addr_ok;
    reg_idx_t             idx;
    logic [NUM_LINES-1:0] bank_rd  [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    intc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_lines),
        .sync_o  (lines_s)
    );

    always_comb begin
        idx     = reg_idx_t'(bus_addr[4:2]);
        addr_ok = (bus_addr[1:0] == 2'b00) &&
                  (bus_addr[ADDR_W-1:HI_LSB] == '0) &&
                  (bus_addr[4:2] <= LAST_REG);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = addr_ok && (bus_addr[BANK_SEL_BIT] == b[0]);
        intc_bank #(.N(NUM_LINES)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lines_i   (lines_s),
            .wr_en_i   (bus_we && sel),
            .idx_i     (idx),
            .wr_data_i (bus_wdata),
            .rd_data_o (bank_rd[b]),
            .irq_o     (bank_irq[b])
        );
    end

    assign bus_rdata = addr_ok ? bank_rd[bus_addr[BANK_SEL_BIT]] : '0;
    assign irq_norm  = bank_irq[0];
    assign irq_fast  = bank_irq[1];

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:HI_LSB] != '0) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/intc_top_test.sv
module intc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n, irq_f;
    int unsigned total = 0;
    int unsigned bad = 0;

    always #4 clk = ~clk;

    intc_top uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_norm(irq_n), .irq_fast(irq_f)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] model(input logic [31:0] o, input logic [31:0] n,
                                         input logic [31:0] m, input logic [31:0] md,
                                         input logic [31:0] p);
        logic [31:0] edg;
        edg = (n & ~o & ~p) | (~n & o & p);
        return ((md & edg) | (~md & (n ^ p))) & m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_val;
        seed_val = $urandom(32'd2024);
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        for (int b = 0; b < 2; b++) begin
            for (int r = 1; r < 6; r++) begin
                rd(8'(b*32 + r*4), v);
                chk("R1 reset reg", v, 32'h0);
            end
        end
        chk("R1 irq low", {30'd0, irq_f, irq_n}, 32'h0);

        // R2 / R11 register map and bank independence
        wr(8'h24, 32'hA5A5_0F0F);
        wr(8'h0C, 32'h1234_5678);
        wr(8'h30, 32'hFFFF_0000);
        rd(8'h24, v); chk("R2 fast mask", v, 32'hA5A5_0F0F);
        rd(8'h0C, v); chk("R2 norm mode", v, 32'h1234_5678);
        rd(8'h30, v); chk("R2 fast pol", v, 32'hFFFF_0000);
        rd(8'h04, v); chk("R11 norm mask untouched", v, 32'h0);
        rd(8'h2C, v); chk("R11 fast mode untouched", v, 32'h0);
        rd(8'h10, v); chk("R11 norm pol untouched", v, 32'h0);

        // R9 unmapped and clear register reads
        rd(8'h18, v); chk("R9 0x18", v, 0);
        rd(8'h3C, v); chk("R9 0x3C", v, 0);
        rd(8'h40, v); chk("R9 0x40", v, 0);
        rd(8'h05, v); chk("R9 misaligned", v, 0);
        rd(8'h28, v); chk("R9 clear reads zero", v, 0);

        // reset config for directed cases
        wr(8'h24, 0); wr(8'h0C, 0); wr(8'h30, 0);

        // R10 two-edge latency, R4 source with polarity, no mask
        wr(8'h10, 32'h0000_00F0);
        @(negedge clk); lines = 32'h0000_0003;
        rd(8'h00, v); chk("R10 not yet", v, 32'h0000_00F0);
        @(negedge clk);
        rd(8'h00, v); chk("R10 after one edge", v, 32'h0000_00F0);
        @(negedge clk);
        rd(8'h00, v); chk("R10/R4 after two edges", v, 32'h0000_00F3);

        // R5 level high/low and R3 status/irq
        wr(8'h04, 32'h0000_00F3);
        settle(1);
        rd(8'h14, v); chk("R5 level status", v, 32'h0000_00F3);
        chk("R3 irq_norm high", {31'd0, irq_n}, 1);
        wr(8'h04, 32'h0000_0001);
        rd(8'h14, v); chk("R3 masked status", v, 32'h1);
        // R7 clear on level line has no effect
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R7 level clear ignored", v, 32'h1);
        @(negedge clk); lines = 32'h0000_0010;
        settle(3);
        rd(8'h14, v); chk("R5 level follows low", v, 32'h0);
        chk("R3 irq_norm low", {31'd0, irq_n}, 0);

        // R6 edge rising and falling, sticky
        wr(8'h04, 0); wr(8'h10, 0);
        @(negedge clk); lines = 32'h0000_000C;
        settle(4);
        wr(8'h2C, 32'h0000_000F);
        wr(8'h30, 32'h0000_000A);
        wr(8'h24, 32'h0000_000F);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h34, v); chk("R6 edge idle", v, 0);
        @(negedge clk); lines = 32'h0000_0003;
        settle(4);
        rd(8'h34, v); chk("R6 rise/fall latched", v, 32'h0000_0009);
        chk("R3 irq_fast high", {31'd0, irq_f}, 1);
        @(negedge clk); lines = 32'h0000_000C;
        settle(4);
        rd(8'h34, v); chk("R6 sticky after return", v, 32'h0000_000F);
        // R7 partial clear
        wr(8'h28, 32'h0000_0005);
        rd(8'h34, v); chk("R7 partial clear", v, 32'h0000_000A);
        wr(8'h28, 32'h0000_000A);
        rd(8'h34, v); chk("R7 full clear", v, 0);
        chk("R3 irq_fast low", {31'd0, irq_f}, 0);

        // R8 edge and clear in the same cycle (line 0, rising)
        @(negedge clk); lines = 32'h0000_0008;
        settle(4);
        wr(8'h28, 32'hFFFF_FFFF);
        @(negedge clk); lines = 32'h0000_0009;
        @(negedge clk);
        @(negedge clk);
        addr = 8'h28; we = 1'b1; wdata = 32'h0000_0001;
        @(negedge clk); we = 1'b0;
        rd(8'h34, v); chk("R8 edge wins over clear", v, 32'h0000_0001);
        wr(8'h28, 32'h0000_0001);
        rd(8'h34, v); chk("R7 later clear", v, 0);

        // random configurations against the model (R3 R5 R6)
        for (int it = 0; it < 30; it++) begin
            logic [31:0] m, md, p, o, n;
            logic [7:0] base;
            base = it[0] ? 8'h20 : 8'h00;
            m = $urandom; md = $urandom; p = $urandom; o = $urandom; n = $urandom;
            @(negedge clk); lines = o;
            settle(4);
            wr(base + 8'h04, m);
            wr(base + 8'h0C, md);
            wr(base + 8'h10, p);
            wr(base + 8'h08, 32'hFFFF_FFFF);
            @(negedge clk); lines = n;
            settle(4);
            rd(base + 8'h14, v);
            chk("R5/R6 random status", v, model(o, n, m, md, p));
            chk("R3 random irq", {31'd0, it[0] ? irq_f : irq_n},
                {31'd0, |model(o, n, m, md, p)});
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule